// File: doc/BRIEF.md
# Protected Instruction Sequence Controller

This block lives in the decode stage of a processor core. It keeps track of the short instruction runs that a sequence prefix opens. A prefix carries a count from one to four. The prefix itself is not counted: the count covers only the instructions that follow it. While such a run is open, the block asks the injection logic to hold back interrupts, peripheral transfers and debug halts. Those events are serviced only after the final protected instruction has retired.

Some prefix kinds also send register-space accesses to the extended register space, and only for the length of the run. The redirect stops on the clock edge at which the final protected instruction retires. It stops there whatever kind of instruction that was, so it also stops when the last one is a conditional branch or call that is not taken. The first register access after the run therefore goes to the normal space.

A trap taken inside a run cancels it at once. Any prefix also raises an issue hold for a fixed number of cycles. This lets older writes in the pipeline settle before the protected instruction is issued.

Top module: `protect_seq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `active_o`, `block_inject_o`, `esfr_sel_o` and `issue_hold_o` are all low.
- R2: When no run is open, a cycle with `retire_i` and `pfx_i` both high (and `trap_i` low) opens a run of `pfx_count_i`+1 instructions (code 0 gives 1, code 3 gives 4). `active_o` is high from the next cycle on.
- R3: While a run is open, each cycle with `retire_i` high uses up one protected instruction, and cycles with `retire_i` low use up none. `active_o` goes low in the cycle after the retire of the last protected instruction.
- R4: `block_inject_o` is high in exactly the cycles in which a run is open.
- R5: Kind codes on `pfx_kind_i`: 0 plain protection, 1 extended-register, 2 page, 3 page plus extended-register, 4 segment, 5 segment plus extended-register, 6 and 7 behave like 0. `esfr_sel_o` is high only when a run is open, its opening prefix had kind 1, 3 or 5, and `sfr_access_i` is high.
- R6: `esfr_sel_o` is low in the cycle after the last protected instruction retires, even with `sfr_access_i` high and whatever class that last instruction had.
- R7: A prefix that retires while a run is open counts as one protected instruction. It neither restarts the count nor changes the kind of the open run.
- R8: `trap_i` high closes any open run and clears the redirect and the issue hold in the next cycle. A prefix retiring in the same cycle as a trap opens no run.
- R9: Each run opening raises `issue_hold_o` for exactly DRAIN_CYC cycles, starting with the cycle after the prefix retires.
- R10: With no run open, a retire that is not a prefix leaves every output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Synchronous active-low reset |
| retire_i | input | 1 | One instruction retires this cycle |
| pfx_i | input | 1 | The retiring instruction is a sequence prefix |
| pfx_count_i | input | CNT_W | Prefix count minus one |
| pfx_kind_i | input | 3 | Prefix kind code |
| trap_i | input | 1 | A trap or exception is taken this cycle |
| sfr_access_i | input | 1 | The current instruction accesses register space |
| active_o | output | 1 | A protected run is open |
| block_inject_o | output | 1 | Hold back interrupt, transfer and halt injection |
| esfr_sel_o | output | 1 | Send this register access to the extended space |
| issue_hold_o | output | 1 | Stall issue while the pipeline drains |

## Verification
The bench sweeps every count code against all eight kind codes. In each run it puts idle cycles between the retires, so that a counter that decrements on time rather than on retires shows up. It runs every combination with `sfr_access_i` both high and low. This tells redirect kinds apart from plain kinds, and shows the redirect being gated by the access flag. A run that ends while `sfr_access_i` stays high shows whether the redirect stops exactly at the last retire. Separate patterns cover a nested prefix with a different kind, a trap in the middle of a run, a trap together with a prefix, and a stray retire while idle.

// File: rtl/protect_seq_pkg.sv
// Package for the protected sequence controller.
// Holds the prefix kind codes and the helper that decides whether a kind
// sends register accesses to the extended space.
package protect_seq_pkg;

    typedef enum logic [2:0] {
        SEQ_PLAIN      = 3'd0,
        SEQ_XREG       = 3'd1,
        SEQ_PAGE       = 3'd2,
        SEQ_PAGE_XREG  = 3'd3,
        SEQ_SEG        = 3'd4,
        SEQ_SEG_XREG   = 3'd5
    } seq_kind_e;

    // True for kinds that redirect register-space accesses.
    function automatic logic kind_redirects(input logic [2:0] kind);
        return (kind == SEQ_XREG) || (kind == SEQ_PAGE_XREG) || (kind == SEQ_SEG_XREG);
    endfunction

endpackage

// File: rtl/seq_left_counter.sv
// Counter of the protected instructions still to retire.
// It assumes that load, dec and clear come from the top with clear
// taking priority and load only ever used while the count is zero.
module seq_left_counter #(
    parameter int LEFT_W = 3
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic              clear_i,
    input  logic              load_i,
    input  logic [LEFT_W-1:0] load_val_i,
    input  logic              dec_i,
    output logic [LEFT_W-1:0] left_o,
    output logic              nonzero_o
);

    logic [LEFT_W-1:0] left_q;

    // Updates the count: reset and trap clear it, a prefix loads it, a retire decrements it.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            left_q <= '0;
        end else if (clear_i) begin
            left_q <= '0;
        end else if (load_i) begin
            left_q <= load_val_i;
        end else if (dec_i && (left_q != '0)) begin
            left_q <= left_q - LEFT_W'(1);
        end
    end

    assign left_o    = left_q;
    assign nonzero_o = (left_q != '0);

endmodule

// File: rtl/seq_mode_reg.sv
// Holds the redirect mode of the open run.
// It assumes that the top gates the stored flag with the active state, so
// the flag need not be cleared when a run ends on its own.
module seq_mode_reg (
    input  logic       clk_i,
    input  logic       rst_n_i,
    input  logic       clear_i,
    input  logic       load_i,
    input  logic [2:0] kind_i,
    output logic       redirect_o
);

    import protect_seq_pkg::*;

    logic redirect_q;

    // Captures the kind's redirect property when a run opens and drops it on a trap.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            redirect_q <= 1'b0;
        end else if (clear_i) begin
            redirect_q <= 1'b0;
        end else if (load_i) begin
            redirect_q <= kind_redirects(kind_i);
        end
    end

    assign redirect_o = redirect_q;

endmodule

// File: rtl/seq_drain_timer.sv
// Issue hold timer that lets earlier writes settle before the first
// protected instruction issues. It assumes DRAIN_CYC is at least 1.
module seq_drain_timer #(
    parameter int DRAIN_CYC = 2
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic clear_i,
    input  logic start_i,
    output logic hold_o
);

    localparam int HW = $clog2(DRAIN_CYC + 1);

    logic [HW-1:0] left_q;

    // Loads the drain length on a run opening and counts it down to zero.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            left_q <= '0;
        end else if (clear_i) begin
            left_q <= '0;
        end else if (start_i) begin
            left_q <= HW'(DRAIN_CYC);
        end else if (left_q != '0) begin
            left_q <= left_q - HW'(1);
        end
    end

    assign hold_o = (left_q != '0);

endmodule

// File: rtl/protect_seq_ctrl.sv
// Protected sequence controller, the top level.
// It opens a run when a prefix retires with no run open, counts retires
// down to the end of the run, blocks injection while the run is open and
// redirects register accesses for redirect kinds. It assumes that at most
// one instruction retires per cycle and that trap_i marks a taken exception.
module protect_seq_ctrl #(
    parameter int CNT_W     = 2,
    parameter int DRAIN_CYC = 2
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic             retire_i,
    input  logic             pfx_i,
    input  logic [CNT_W-1:0] pfx_count_i,
    input  logic [2:0]       pfx_kind_i,
    input  logic             trap_i,
    input  logic             sfr_access_i,
    output logic             active_o,
    output logic             block_inject_o,
    output logic             esfr_sel_o,
    output logic             issue_hold_o
);

    localparam int LEFT_W = CNT_W + 1;

    logic              seq_open;
    logic              seq_start;
    logic              seq_dec;
    logic [LEFT_W-1:0] seq_left;
    logic [LEFT_W-1:0] seq_load_val;
    logic              seq_redirect;

    // Decodes the run opening and the per-retire step from the strobes.
    always_comb begin
        seq_start    = retire_i && pfx_i && !seq_open && !trap_i;
        seq_dec      = retire_i && seq_open && !trap_i;
        seq_load_val = {1'b0, pfx_count_i} + LEFT_W'(1);
    end

    seq_left_counter #(
        .LEFT_W(LEFT_W)
    ) u_count (
        .clk_i      (clk_i),
        .rst_n_i    (rst_n_i),
        .clear_i    (trap_i),
        .load_i     (seq_start),
        .load_val_i (seq_load_val),
        .dec_i      (seq_dec),
        .left_o     (seq_left),
        .nonzero_o  (seq_open)
    );

    seq_mode_reg u_mode (
        .clk_i      (clk_i),
        .rst_n_i    (rst_n_i),
        .clear_i    (trap_i),
        .load_i     (seq_start),
        .kind_i     (pfx_kind_i),
        .redirect_o (seq_redirect)
    );

    seq_drain_timer #(
        .DRAIN_CYC(DRAIN_CYC)
    ) u_drain (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .clear_i (trap_i),
        .start_i (seq_start),
        .hold_o  (issue_hold_o)
    );

    // Drives the run outputs from the registered run state.
    always_comb begin
        active_o       = seq_open;
        block_inject_o = seq_open;
        esfr_sel_o     = seq_open && seq_redirect && sfr_access_i;
    end

endmodule

// File: rtl/protect_seq_checks.sv
// Checker bound to the protected sequence controller. It relates the
// strobes to the run state across cycles.
module protect_seq_checks #(
    parameter int LEFT_W = 3
) (
    input logic              clk_i,
    input logic              rst_n_i,
    input logic              retire_i,
    input logic              pfx_i,
    input logic              trap_i,
    input logic              active_o,
    input logic              block_inject_o,
    input logic              esfr_sel_o,
    input logic [LEFT_W-1:0] left_i
);

    localparam int MAX_LEFT = 1 << (LEFT_W - 1);

    assert_open_bounded_R2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        active_o |-> (left_i <= LEFT_W'(MAX_LEFT)));

    assert_end_on_event_R3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $fell(active_o) |-> $past(retire_i || trap_i));

    assert_block_holds_R4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (block_inject_o && !retire_i && !trap_i) |=> block_inject_o);

    assert_redirect_inside_R5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        esfr_sel_o |-> block_inject_o);

    assert_trap_cancel_R8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        trap_i |=> (!active_o && !esfr_sel_o));

    assert_idle_stays_R10: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (!active_o && !(retire_i && pfx_i)) |=> !active_o);

endmodule

bind protect_seq_ctrl protect_seq_checks #(
    .LEFT_W(LEFT_W)
) u_checks (
    .clk_i          (clk_i),
    .rst_n_i        (rst_n_i),
    .retire_i       (retire_i),
    .pfx_i          (pfx_i),
    .trap_i         (trap_i),
    .active_o       (active_o),
    .block_inject_o (block_inject_o),
    .esfr_sel_o     (esfr_sel_o),
    .left_i         (seq_left)
);

// File: tb/sim_protect_seq_ctrl.sv
module sim_protect_seq_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 2;
    localparam int DRAIN      = 2;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             retire;
    logic             pfx;
    logic [CNT_W-1:0] cnt;
    logic [2:0]       kind;
    logic             trap;
    logic             sfr;
    logic             active, block, esfr, hold;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Expected state built from the requirements.
    int e_left  = 0;
    bit e_redir = 1'b0;
    int e_hold  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    protect_seq_ctrl #(.CNT_W(CNT_W), .DRAIN_CYC(DRAIN)) u0 (
        .clk_i(clk), .rst_n_i(rst_n), .retire_i(retire), .pfx_i(pfx),
        .pfx_count_i(cnt), .pfx_kind_i(kind), .trap_i(trap), .sfr_access_i(sfr),
        .active_o(active), .block_inject_o(block), .esfr_sel_o(esfr), .issue_hold_o(hold)
    );

    task automatic check(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    // One clock with the given inputs, then all outputs compared.
    task automatic step(input string tag, input bit r, input bit p, input int c,
                        input int k, input bit t, input bit s);
        @(negedge clk);
        retire = r; pfx = p; cnt = CNT_W'(c); kind = 3'(k); trap = t; sfr = s;
        if (t) begin
            e_left = 0; e_redir = 1'b0; e_hold = 0;
        end else if (e_left == 0) begin
            if (e_hold > 0) e_hold--;
            if (r && p) begin
                e_left  = c + 1;
                e_redir = (k == 1) || (k == 3) || (k == 5);
                e_hold  = DRAIN;
            end
        end else begin
            if (e_hold > 0) e_hold--;
            if (r) e_left--;
        end
        @(posedge clk);
        #1;
        check(tag, "active", active, e_left != 0);
        check("R4", "block", block, e_left != 0);
        check(tag, "esfr", esfr, (e_left != 0) && e_redir && s);
        check("R9", "hold", hold, e_hold != 0);
    endtask

    initial begin
        rst_n = 1'b0; retire = 0; pfx = 0; cnt = '0; kind = '0; trap = 0; sfr = 0;
        repeat (3) @(posedge clk);
        #1;
        check("R1", "active", active, 1'b0);
        check("R1", "block", block, 1'b0);
        check("R1", "esfr", esfr, 1'b0);
        check("R1", "hold", hold, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // R10: stray retire while idle
        step("R10", 1, 0, 0, 1, 0, 1);
        step("R10", 1, 0, 3, 5, 0, 1);

        // R2 R3 R5 R6: full sweep of count and kind, with idle gaps
        for (int k = 0; k < 8; k++) begin
            for (int c = 0; c < 4; c++) begin
                for (int s = 0; s < 2; s++) begin
                    step("R2", 1, 1, c, k, 0, s[0]);
                    for (int i = 0; i <= c; i++) begin
                        step("R3", 0, 0, 0, 0, 0, s[0]);
                        step("R5", 0, 0, 0, 0, 0, s[0]);
                        step("R6", 1, 0, 0, 0, 0, s[0]);
                    end
                    step("R6", 0, 0, 0, 0, 0, 1);
                    step("R3", 0, 0, 0, 0, 0, 0);
                end
            end
        end

        // R7: nested prefix of another kind inside a redirect run
        step("R7", 1, 1, 2, 1, 0, 1);
        step("R7", 1, 1, 3, 0, 0, 1);
        step("R7", 0, 0, 0, 0, 0, 1);
        step("R7", 1, 1, 3, 4, 0, 1);
        step("R7", 0, 0, 0, 0, 0, 1);
        step("R7", 1, 0, 0, 0, 0, 1);
        step("R7", 0, 0, 0, 0, 0, 1);

        // R8: trap in mid run, then trap together with a prefix
        step("R8", 1, 1, 3, 5, 0, 1);
        step("R8", 1, 0, 0, 0, 0, 1);
        step("R8", 0, 0, 0, 0, 1, 1);
        step("R8", 0, 0, 0, 0, 0, 1);
        step("R8", 1, 1, 3, 1, 1, 1);
        step("R8", 0, 0, 0, 0, 0, 1);
        step("R8", 1, 1, 0, 3, 0, 1);
        step("R8", 1, 0, 0, 0, 0, 1);
        step("R8", 0, 0, 0, 0, 0, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule